// File: doc/BRIEF.md
# Two-Wire Bus Master Register and Interrupt Unit

This block is the software-visible front end of a two-wire serial bus master. A host reaches it over a simple 32-bit register bus with single-cycle writes and combinational reads at word offsets. It stores the bus timing fields, the controller configuration, the transfer command, the target address and two data words. It presents all of these as plain outputs to a bit-level bus engine. That engine is not part of this block and appears here only as event pulses, a busy level and a receive-data load.

Completion and error events from the engine land in a sticky status register, which software clears by writing back ones. The status is ANDed with a mask register and reduced to a single interrupt line. Software that enables only the completion flag therefore takes one interrupt per transfer and can still read every error flag afterwards. A fixed-priority encoder reduces the error flags to one result code, so software does not have to decode them.

Top module: `twm_csr`

## Requirements
- R1: After reset, both clock registers read 0x0000301F (filter 3, divider 0x01F). The configuration register reads 0x00003302 (arbitration filter 3, NAK count 3, arbitration enable 1). Mask, status, command, address and data registers read 0. `irq` is 0 and `result` is 0.
- R2: Register map by word offset: 0x00 standard clock, 0x04 high-speed clock, 0x08 configuration, 0x0C command, 0x10 target address, 0x14 data low, 0x18 data high, 0x1C status, 0x20 mask, 0x24 busy. A clock register keeps only bits 15:12 (filter) and 9:0 (divider). The configuration register keeps bits 15:12 (arbitration filter), 11:8 (NAK count), 7 (10-bit addressing), 6:4 (master code), 1 (arbitration enable) and 0 (high-speed mode). All other bits read 0, and each field drives its matching output.
- R3: Status bits are 0 done, 1 arbitration lost, 2 no acknowledge, 3 data collision, 4 bus busy. A one on `eng_evt[i]` sets bit i on the next edge. A bit stays set until software clears it.
- R4: Writing to 0x1C clears each status bit whose written bit is 1 and leaves bits written 0 unchanged.
- R5: When an engine event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly when some status bit and its mask bit (offset 0x20, same bit positions) are both 1. With mask 0x01, an error flag alone keeps `irq` low, and the later done event raises it while the error flag stays readable.
- R7: `result` encodes status by fixed priority: arbitration lost gives 5, else no acknowledge gives 4, else data collision gives 3, else bus busy gives 2, else 0.
- R8: Offset 0x24 reads `eng_busy` live in bit 0. A command write made while `eng_busy` is 1 is ignored: the command register keeps its value and `cmd_go` stays low.
- R9: Command fields: bits 1:0 type (0 write, 1 read, 2 write then read), bits 7:4 write length, bits 11:8 read length. A length above 8 is stored as 8. An accepted command write raises `cmd_go` for exactly the one cycle after the write edge.
- R10: Data words are writable at 0x14/0x18 and drive `tx_data` as {high, low}. A `rx_load` pulse overwrites both words with `rx_data` on the next edge.
- R11: Offsets 0x28 to 0x3C and any address with bits 1:0 nonzero read as 0. Writes to them, and to the read-only busy offset, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| eng_evt | input | 5 | Event pulses from the bus engine, one per status bit |
| eng_busy | input | 1 | Engine busy level |
| rx_load | input | 1 | Load both data words from `rx_data` |
| rx_data | input | 64 | Received data, high word in bits 63:32 |
| sf_filt | output | 4 | Standard/fast clock glitch filter |
| sf_div | output | 10 | Standard/fast clock divider |
| hs_filt | output | 4 | High-speed clock glitch filter |
| hs_div | output | 10 | High-speed clock divider |
| arb_filt | output | 4 | Arbitration filter |
| nak_cnt | output | 4 | NAK count |
| addr10 | output | 1 | 10-bit addressing enable |
| mcode | output | 3 | High-speed master code |
| arb_en | output | 1 | Arbitration enable |
| hs_mode | output | 1 | High-speed mode enable |
| cmd_type | output | 2 | Command type |
| cmd_wlen | output | 4 | Write byte count, 0 to 8 |
| cmd_rlen | output | 4 | Read byte count, 0 to 8 |
| cmd_go | output | 1 | One-cycle start pulse |
| slave_addr | output | 10 | Target address |
| tx_data | output | 64 | Data words {high, low} |
| irq | output | 1 | Interrupt request |
| result | output | 3 | Encoded transfer result |

## Verification
On every cycle the checker confirms several properties. Every engine event leaves its status bit set on the next edge, even against a clear. No status bit falls without a status write. A start pulse only follows an accepted command write, and never follows one made while busy. The result code follows the priority. Only the bench's scenarios can show the reset values, the field packing and masking of the clock and configuration words, and length saturation. They also cover the single-interrupt sequence under a done-only mask, the data-word load path and the inertness of unmapped offsets.

// File: rtl/twm_csr.sv
module twm_csr #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int DIVW  = 10,
  parameter int FLTW  = 4,
  parameter int NFLAG = 5,
  parameter int LENW  = 4,
  parameter int MAXB  = 8,
  parameter int SAW   = 10,
  parameter int MCW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NFLAG-1:0] eng_evt,
  input  logic            eng_busy,
  input  logic            rx_load,
  input  logic [2*DW-1:0] rx_data,
  output logic [FLTW-1:0] sf_filt,
  output logic [DIVW-1:0] sf_div,
  output logic [FLTW-1:0] hs_filt,
  output logic [DIVW-1:0] hs_div,
  output logic [FLTW-1:0] arb_filt,
  output logic [FLTW-1:0] nak_cnt,
  output logic            addr10,
  output logic [MCW-1:0]  mcode,
  output logic            arb_en,
  output logic            hs_mode,
  output logic [1:0]      cmd_type,
  output logic [LENW-1:0] cmd_wlen,
  output logic [LENW-1:0] cmd_rlen,
  output logic            cmd_go,
  output logic [SAW-1:0]  slave_addr,
  output logic [2*DW-1:0] tx_data,
  output logic            irq,
  output logic [2:0]      result
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] A_SFC = 0, A_HSC = 1, A_CFG = 2, A_CMD = 3, A_SLA = 4,
                            A_DL = 5, A_DH = 6, A_STS = 7, A_MSK = 8, A_BSY = 9;
  localparam logic [FLTW-1:0] FLT_RST = FLTW'(3);
  localparam logic [DIVW-1:0] DIV_RST = DIVW'(31);
  localparam logic [LENW-1:0] LMAX = LENW'(MAXB);

  logic [IW-1:0]    idx;
  logic             aligned, wr_any;
  logic [NFLAG-1:0] sts_q, msk_q, sts_clr;
  logic [DW-1:0]    dlo_q, dhi_q;
  logic             cmd_ok;
  logic             unused_bits;

  assign idx     = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_any  = bus_wr && aligned;
  assign cmd_ok  = wr_any && idx == A_CMD && !eng_busy;
  assign sts_clr = (wr_any && idx == A_STS) ? bus_wdata[NFLAG-1:0] : '0;
  assign unused_bits = ^bus_wdata[DW-1:16];

  function automatic logic [LENW-1:0] sat_len(input logic [LENW-1:0] v);
    return (v > LMAX) ? LMAX : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_filt <= FLT_RST;  sf_div <= DIV_RST;
      hs_filt <= FLT_RST;  hs_div <= DIV_RST;
      arb_filt <= FLT_RST; nak_cnt <= FLT_RST;
      addr10 <= 1'b0; mcode <= '0; arb_en <= 1'b1; hs_mode <= 1'b0;
      cmd_type <= '0; cmd_wlen <= '0; cmd_rlen <= '0; cmd_go <= 1'b0;
      slave_addr <= '0;
      dlo_q <= '0; dhi_q <= '0;
      sts_q <= '0; msk_q <= '0;
    end else begin
      cmd_go <= cmd_ok;
      sts_q  <= (sts_q & ~sts_clr) | eng_evt;
      if (cmd_ok) begin
        cmd_type <= bus_wdata[1:0];
        cmd_wlen <= sat_len(bus_wdata[4 +: LENW]);
        cmd_rlen <= sat_len(bus_wdata[8 +: LENW]);
      end
      if (wr_any) begin
        case (idx)
          A_SFC: begin sf_filt <= bus_wdata[12 +: FLTW]; sf_div <= bus_wdata[DIVW-1:0]; end
          A_HSC: begin hs_filt <= bus_wdata[12 +: FLTW]; hs_div <= bus_wdata[DIVW-1:0]; end
          A_CFG: begin
            arb_filt <= bus_wdata[12 +: FLTW];
            nak_cnt  <= bus_wdata[8 +: FLTW];
            addr10   <= bus_wdata[7];
            mcode    <= bus_wdata[4 +: MCW];
            arb_en   <= bus_wdata[1];
            hs_mode  <= bus_wdata[0];
          end
          A_SLA: slave_addr <= bus_wdata[SAW-1:0];
          A_MSK: msk_q <= bus_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
      if (rx_load) begin
        dlo_q <= rx_data[DW-1:0];
        dhi_q <= rx_data[2*DW-1:DW];
      end else if (wr_any && idx == A_DL) begin
        dlo_q <= bus_wdata;
      end else if (wr_any && idx == A_DH) begin
        dhi_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        A_SFC: begin bus_rdata[12 +: FLTW] = sf_filt; bus_rdata[DIVW-1:0] = sf_div; end
        A_HSC: begin bus_rdata[12 +: FLTW] = hs_filt; bus_rdata[DIVW-1:0] = hs_div; end
        A_CFG: begin
          bus_rdata[12 +: FLTW] = arb_filt;
          bus_rdata[8 +: FLTW]  = nak_cnt;
          bus_rdata[7]          = addr10;
          bus_rdata[4 +: MCW]   = mcode;
          bus_rdata[1]          = arb_en;
          bus_rdata[0]          = hs_mode;
        end
        A_CMD: begin
          bus_rdata[1:0]      = cmd_type;
          bus_rdata[4 +: LENW] = cmd_wlen;
          bus_rdata[8 +: LENW] = cmd_rlen;
        end
        A_SLA: bus_rdata[SAW-1:0] = slave_addr;
        A_DL:  bus_rdata = dlo_q;
        A_DH:  bus_rdata = dhi_q;
        A_STS: bus_rdata[NFLAG-1:0] = sts_q;
        A_MSK: bus_rdata[NFLAG-1:0] = msk_q;
        A_BSY: bus_rdata[0] = eng_busy;
        default: ;
      endcase
    end
  end

  assign tx_data = {dhi_q, dlo_q};
  assign irq = |(sts_q & msk_q);

  always_comb begin
    if (sts_q[1])      result = 3'd5;
    else if (sts_q[2]) result = 3'd4;
    else if (sts_q[3]) result = 3'd3;
    else if (sts_q[4]) result = 3'd2;
    else               result = 3'd0;
  end
endmodule

module twm_csr_chk #(
  parameter int AW = 6,
  parameter int NFLAG = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [NFLAG-1:0] eng_evt,
  input logic             eng_busy,
  input logic [NFLAG-1:0] sts_q,
  input logic [NFLAG-1:0] msk_q,
  input logic             irq,
  input logic [2:0]       result,
  input logic             cmd_go
);
  logic sts_wr, cmd_wr;
  assign sts_wr = bus_wr && bus_addr == AW'(8'h1C);
  assign cmd_wr = bus_wr && bus_addr == AW'(8'h0C);

  // R3 R5
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_evt != '0) |=> ((sts_q & $past(eng_evt)) == $past(eng_evt)));
  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));
  // R7
  arb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[1] |-> (result == 3'd5));
  // R7
  ok_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[4:1] == 4'b0) |-> (result == 3'd0));
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && eng_busy) |=> !cmd_go);
  // R9
  go_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> $past(cmd_wr && !eng_busy));
endmodule

bind twm_csr twm_csr_chk #(.AW(AW), .NFLAG(NFLAG)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .eng_evt(eng_evt), .eng_busy(eng_busy), .sts_q(sts_q), .msk_q(msk_q),
  .irq(irq), .result(result), .cmd_go(cmd_go));

// File: tb/twm_csr_tb_top.sv
module twm_csr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0] eng_evt = '0;
  logic eng_busy = 1'b0;
  logic rx_load = 1'b0;
  logic [63:0] rx_data = '0;
  logic [3:0] sf_filt, hs_filt, arb_filt, nak_cnt;
  logic [9:0] sf_div, hs_div, slave_addr;
  logic addr10, arb_en, hs_mode, cmd_go, irq;
  logic [2:0] mcode, result;
  logic [1:0] cmd_type;
  logic [3:0] cmd_wlen, cmd_rlen;
  logic [63:0] tx_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  twm_csr dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    eng_evt = e;
    @(negedge clk);
    eng_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); chk("R1 sf clock", d, 32'h301F);
    rd(6'h04, d); chk("R1 hs clock", d, 32'h301F);
    rd(6'h08, d); chk("R1 config", d, 32'h3302);
    rd(6'h0C, d); chk("R1 command", d, 0);
    rd(6'h1C, d); chk("R1 status", d, 0);
    rd(6'h20, d); chk("R1 mask", d, 0);
    chk("R1 irq/result/go", {irq, result, cmd_go}, 0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); chk("R2 sf packing", d, 32'hF3FF);
    chk("R2 sf outputs", {sf_filt, sf_div}, {4'hF, 10'h3FF});
    wr(6'h04, 32'h0001_2345);
    rd(6'h04, d); chk("R2 hs packing", d, 32'h2345);
    chk("R2 hs outputs", {hs_filt, hs_div}, {4'h2, 10'h345});
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R2 cfg all ones", d, 32'hFFF3);
    wr(6'h08, 32'h0000_5A51);
    rd(6'h08, d); chk("R2 cfg pattern", d, 32'h5A51);
    chk("R2 cfg outputs", {arb_filt, nak_cnt, addr10, mcode, arb_en, hs_mode},
        {4'h5, 4'hA, 1'b0, 3'h5, 1'b0, 1'b1});
    wr(6'h10, 32'hFFFF_FEED);
    chk("R2 slave addr", slave_addr, 10'h2ED);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    pulse(5'h06);
    @(negedge clk);
    rd(6'h1C, d); chk("R3 sticky", d, 32'h06);
    wr(6'h1C, 32'h02);
    rd(6'h1C, d); chk("R4 clear one", d, 32'h04);
    wr(6'h1C, 32'h00);
    rd(6'h1C, d); chk("R4 zero write", d, 32'h04);
    wr(6'h1C, 32'h1F);
    rd(6'h1C, d); chk("R4 clear all", d, 32'h00);
  endtask

  task automatic t_race;
    logic [31:0] d;
    pulse(5'h05);
    eng_evt = 5'h04;
    wr(6'h1C, 32'h1F);
    eng_evt = '0;
    rd(6'h1C, d); chk("R5 event beats clear", d, 32'h04);
    wr(6'h1C, 32'h1F);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(6'h20, 32'h01);
    pulse(5'h08);
    chk("R6 error alone no irq", irq, 1'b0);
    pulse(5'h01);
    chk("R6 irq at done", irq, 1'b1);
    rd(6'h1C, d); chk("R6 error still readable", d, 32'h09);
    wr(6'h1C, d);
    chk("R6 irq cleared", irq, 1'b0);
    wr(6'h20, 32'h1F);
    pulse(5'h10);
    chk("R6 full mask error irq", irq, 1'b1);
    wr(6'h1C, 32'h1F);
    wr(6'h20, 32'h00);
  endtask

  task automatic t_result;
    pulse(5'h1E); chk("R7 arbitration first", result, 3'd5);
    wr(6'h1C, 32'h02); chk("R7 no ack next", result, 3'd4);
    wr(6'h1C, 32'h04); chk("R7 collision next", result, 3'd3);
    wr(6'h1C, 32'h08); chk("R7 busy last", result, 3'd2);
    wr(6'h1C, 32'h10); pulse(5'h01); chk("R7 done only ok", result, 3'd0);
    wr(6'h1C, 32'h1F);
  endtask

  task automatic t_cmd;
    logic [31:0] d;
    wr(6'h0C, 32'h0000_0C32);
    chk("R9 go pulse", cmd_go, 1'b1);
    chk("R9 fields saturate", {cmd_type, cmd_wlen, cmd_rlen}, {2'd2, 4'd3, 4'd8});
    @(negedge clk);
    chk("R9 go one cycle", cmd_go, 1'b0);
    rd(6'h0C, d); chk("R9 cmd readback", d, 32'h0832);
    eng_busy = 1'b1;
    rd(6'h24, d); chk("R8 busy reads 1", d, 32'h1);
    wr(6'h0C, 32'h0000_0F91);
    chk("R8 no go while busy", cmd_go, 1'b0);
    rd(6'h0C, d); chk("R8 cmd unchanged", d, 32'h0832);
    eng_busy = 1'b0;
    rd(6'h24, d); chk("R8 busy reads 0", d, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    wr(6'h14, 32'hA5A5_0001);
    wr(6'h18, 32'h1234_5678);
    chk("R10 tx data", tx_data, 64'h1234_5678_A5A5_0001);
    rx_data = 64'hDEAD_BEEF_CAFE_F00D;
    rx_load = 1'b1;
    @(negedge clk);
    rx_load = 1'b0;
    rd(6'h14, d); chk("R10 rx low", d, 32'hCAFE_F00D);
    rd(6'h18, d); chk("R10 rx high", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(6'h28, d); chk("R11 unmapped 0x28", d, 0);
    rd(6'h3C, d); chk("R11 unmapped 0x3C", d, 0);
    rd(6'h01, d); chk("R11 misaligned read", d, 0);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h21, 32'hFFFF_FFFF);
    wr(6'h0D, 32'h0000_0001);
    rd(6'h20, d); chk("R11 mask untouched", d, 0);
    rd(6'h24, d); chk("R11 busy untouched", d, 0);
    rd(6'h0C, d); chk("R11 cmd untouched", d, 32'h0832);
    rd(6'h14, d); chk("R11 data untouched", d, 32'hCAFE_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_sticky();
    t_race();
    t_irq();
    t_result();
    t_cmd();
    t_data();
    t_unmapped();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule